// File: doc/BRIEF.md
# Fractional Reference Clock Divider

This block makes a reference clock from one of several input clocks. The ratio is a whole number plus a fraction in 1/512 steps. Every input clock is given as a one-cycle enable pulse inside a single system clock domain. The output is a level in that same domain. It toggles once per output half-period, so the output frequency is fin / (2 × (DIV + TRIM/512)). If both DIV and TRIM are zero, the selected input passes straight through.

Software reaches the block through two 32-bit words: a control word and a trim word. Each write can store the data, set the chosen bits or clear the chosen bits. The integer ratio, the fraction and the source select are held in shadow fields. A self-clearing switch bit copies the shadow fields into the running divider. While the divider runs, the copy waits for the next half-period boundary, so the output never has a short pulse. The shadow fields and the source select are locked while the block is active or while a switch is still pending.

Top module: `frac_refclk_div`

## Requirements
- R1: After reset, the control word reads 0, the trim word reads 0 and `refClk` is 0.
- R2: Control word (address 0) layout: source select in bits 3:0, ACTIVE (read-only) in bit 4, switch request in bit 5, output enable in bit 6, ON in bit 7, and the integer ratio DIV in bits 22:8. All other bits read 0. Trim word (address 1): TRIM in bits 8:0, all other bits read 0. `wrOp` 0 stores the data, 1 ORs the data into the word, 2 clears the data bits in the word, and 3 does nothing.
- R3: With TRIM = 0 and DIV ≥ 1, every output half-period lasts exactly DIV ticks of the selected source.
- R4: With TRIM ≠ 0, a 9-bit accumulator starts at 0. At every half-period end, TRIM is added to it. The next half-period lasts DIV ticks, or DIV+1 ticks when that addition carries out of bit 8.
- R5: With DIV = 0 and TRIM = 0 (pass-through), `refClk` is high for the one system cycle after each selected tick and low otherwise.
- R6: With DIV = 0 and TRIM ≠ 0, the integer part counts as one tick, and the R4 stretching still applies.
- R7: Only ticks of `srcTick[sel]` advance the divider. Other inputs are ignored, and a select of N_SRC or more never ticks.
- R8: Writing 1 to the switch bit (with op 0 or 1) sets it. When the block is idle, the bit clears on the following cycle. When the block is running, it clears at the next half-period end, and from that half-period on the new settings apply.
- R9: Writes to the select, DIV and TRIM fields have no effect while ACTIVE or the switch bit reads 1.
- R10: ACTIVE reads 1 while ON is set or the output is high. If ON is cleared during a high phase, that phase still runs its full length, and ACTIVE then reads 0.
- R11: Clearing output enable forces `refClk` low and leaves the divider running (ACTIVE stays 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcTick | input | N_SRC | One enable pulse per input clock period, one bit per source |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | Write target: 0 control, 1 trim |
| wrOp | input | 2 | Write mode: store, set, clear, none |
| wrData | input | 32 | Write data or bit mask |
| rdAddr | input | 1 | Read target: 0 control, 1 trim |
| rdData | output | 32 | Read data for `rdAddr` (combinational) |
| refClk | output | 1 | Reference clock level, gated by output enable |

## Verification
The assertions assume that a switch is only raised while the shadow fields hold the settings software wants. They also assume that the source select never changes while the block is active, since that would change the tick stream in the middle of a half-period. The stimulus keeps to this: it programs the fields only after ACTIVE reads 0. It writes the fields while running only to confirm they are ignored. It raises a running switch only after loading the new shadow values while the block was idle. The input ticks come from free-running generators (every cycle, and every third cycle), so each measured half-period is a whole number of system cycles.

// File: rtl/frac_refdiv_pkg.sv
package frac_refdiv_pkg;
  localparam int DATA_W     = 32;
  localparam int SEL_FW     = 4;
  localparam int SEL_LSB    = 0;
  localparam int BUSY_BIT   = 4;
  localparam int SWITCH_BIT = 5;
  localparam int OE_BIT     = 6;
  localparam int ON_BIT     = 7;
  localparam int DIV_LSB    = 8;

  typedef enum logic [1:0] {
    OP_STORE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_NONE  = 2'd3
  } wr_op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadSettings;
    logic runOn;
  } dp_strobe_t;
endpackage

// File: rtl/refdiv_ctrl.sv
module refdiv_ctrl
  import frac_refdiv_pkg::*;
#(
  parameter int DIV_W  = 15,
  parameter int TRIM_W = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                wrAddr,
  input  logic [1:0]          wrOp,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                rdAddr,
  output logic [DATA_W-1:0]   rdData,
  input  logic                dpBoundary,
  input  logic                dpLevel,
  output dp_strobe_t          strobes,
  output logic [DIV_W-1:0]    shDivO,
  output logic [TRIM_W-1:0]   shTrimO,
  output logic [SEL_FW-1:0]   srcSelO,
  output logic                outEnO
);
  localparam int DIV_TOP = DIV_LSB + DIV_W;

  logic [SEL_FW-1:0] srcSel;
  logic              runOn, outEn, switchReq;
  logic [DIV_W-1:0]  shDiv;
  logic [TRIM_W-1:0] shTrim;
  logic              busy, loadNow, fieldLock, wrAct, ctrlWr, trimWr;
  logic [DATA_W-1:0] ctrlWord, trimWord, baseWord, newWord;

  assign busy      = runOn | dpLevel;
  assign fieldLock = busy | switchReq;
  assign loadNow   = switchReq & (~busy | dpBoundary);
  assign wrAct     = wrEn & (wrOp != OP_NONE);
  assign ctrlWr    = wrAct & ~wrAddr;
  assign trimWr    = wrAct & wrAddr;

  always_comb begin
    ctrlWord = '0;
    ctrlWord[SEL_LSB +: SEL_FW] = srcSel;
    ctrlWord[BUSY_BIT]          = busy;
    ctrlWord[SWITCH_BIT]        = switchReq;
    ctrlWord[OE_BIT]            = outEn;
    ctrlWord[ON_BIT]            = runOn;
    ctrlWord[DIV_LSB +: DIV_W]  = shDiv;
    trimWord = '0;
    trimWord[TRIM_W-1:0] = shTrim;
  end

  assign rdData = rdAddr ? trimWord : ctrlWord;

  always_comb begin
    baseWord = wrAddr ? trimWord : ctrlWord;
    if (!wrAddr) begin
      baseWord[BUSY_BIT]   = 1'b0;
      baseWord[SWITCH_BIT] = 1'b0;
    end
    case (wrOp)
      OP_SET:   newWord = baseWord | wrData;
      OP_CLEAR: newWord = baseWord & ~wrData;
      default:  newWord = wrData;
    endcase
  end

  logic unusedBits;
  assign unusedBits = ^{newWord[BUSY_BIT], newWord[DATA_W-1:DIV_TOP], newWord[DATA_W-1:TRIM_W]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcSel    <= '0;
      runOn     <= 1'b0;
      outEn     <= 1'b0;
      switchReq <= 1'b0;
      shDiv     <= '0;
      shTrim    <= '0;
    end else begin
      switchReq <= (switchReq & ~loadNow) | (ctrlWr & newWord[SWITCH_BIT]);
      if (ctrlWr) begin
        runOn <= newWord[ON_BIT];
        outEn <= newWord[OE_BIT];
        if (!fieldLock) begin
          srcSel <= newWord[SEL_LSB +: SEL_FW];
          shDiv  <= newWord[DIV_LSB +: DIV_W];
        end
      end
      if (trimWr && !fieldLock) shTrim <= newWord[TRIM_W-1:0];
    end
  end

  assign strobes.loadSettings = loadNow;
  assign strobes.runOn        = runOn;
  assign shDivO  = shDiv;
  assign shTrimO = shTrim;
  assign srcSelO = srcSel;
  assign outEnO  = outEn;

  // R8
  switch_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(switchReq) |-> ($past(!busy) || $past(dpBoundary)));

  // R9
  field_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy || switchReq) |=> ($stable(shDiv) && $stable(shTrim) && $stable(srcSel)));
endmodule

// File: rtl/refdiv_core.sv
module refdiv_core
  import frac_refdiv_pkg::*;
#(
  parameter int N_SRC  = 4,
  parameter int DIV_W  = 15,
  parameter int TRIM_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strobes,
  input  logic [DIV_W-1:0]  shDiv,
  input  logic [TRIM_W-1:0] shTrim,
  input  logic [SEL_FW-1:0] srcSel,
  input  logic [N_SRC-1:0]  srcTick,
  output logic              refLevel,
  output logic              boundary
);
  localparam int LEN_W = DIV_W + 1;

  logic [DIV_W-1:0]  divLive;
  logic [TRIM_W-1:0] trimLive;
  logic [LEN_W-1:0]  cnt, curLen;
  logic [TRIM_W-1:0] acc;
  logic [TRIM_W:0]   sum;
  logic              selTick, running, passLive, lastTick;

  function automatic logic [LEN_W-1:0] baseLen(input logic [DIV_W-1:0] d);
    return (d == '0) ? LEN_W'(1) : {1'b0, d};
  endfunction

  always_comb begin
    selTick = 1'b0;
    for (int i = 0; i < N_SRC; i++)
      if (srcSel == SEL_FW'(i)) selTick = srcTick[i];
  end

  assign running  = strobes.runOn | refLevel;
  assign passLive = (divLive == '0) && (trimLive == '0);
  assign lastTick = (cnt == curLen - LEN_W'(1));
  assign boundary = running & selTick & (passLive | lastTick);
  assign sum      = {1'b0, acc} + {1'b0, trimLive};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divLive  <= '0;
      trimLive <= '0;
      cnt      <= '0;
      curLen   <= LEN_W'(1);
      acc      <= '0;
      refLevel <= 1'b0;
    end else if (!running) begin
      refLevel <= 1'b0;
      cnt      <= '0;
      acc      <= '0;
      if (strobes.loadSettings) begin
        divLive  <= shDiv;
        trimLive <= shTrim;
        curLen   <= baseLen(shDiv);
      end else begin
        curLen   <= baseLen(divLive);
      end
    end else if (passLive) begin
      refLevel <= selTick & strobes.runOn;
      cnt      <= '0;
      acc      <= '0;
      if (strobes.loadSettings) begin
        divLive  <= shDiv;
        trimLive <= shTrim;
        curLen   <= baseLen(shDiv);
      end
    end else if (selTick) begin
      if (lastTick) begin
        refLevel <= ~refLevel;
        cnt      <= '0;
        if (strobes.loadSettings) begin
          divLive  <= shDiv;
          trimLive <= shTrim;
          acc      <= '0;
          curLen   <= baseLen(shDiv);
        end else begin
          acc      <= sum[TRIM_W-1:0];
          curLen   <= baseLen(divLive) + LEN_W'(sum[TRIM_W]);
        end
      end else begin
        cnt <= cnt + LEN_W'(1);
      end
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && !passLive) |-> (cnt < curLen));

  // R4
  len_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && !passLive) |->
      ((curLen >= baseLen(divLive)) && (curLen <= baseLen(divLive) + LEN_W'(1))));

  // R7
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && !passLive && !selTick) |=> $stable(refLevel));

  // R10
  high_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refLevel && !boundary && !passLive) |=> refLevel);
endmodule

// File: rtl/frac_refclk_div.sv
module frac_refclk_div
  import frac_refdiv_pkg::*;
#(
  parameter int N_SRC  = 4,
  parameter int DIV_W  = 15,
  parameter int TRIM_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_SRC-1:0]  srcTick,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [1:0]        wrOp,
  input  logic [31:0]       wrData,
  input  logic              rdAddr,
  output logic [31:0]       rdData,
  output logic              refClk
);
  dp_strobe_t        strobes;
  logic [DIV_W-1:0]  shDiv;
  logic [TRIM_W-1:0] shTrim;
  logic [SEL_FW-1:0] srcSel;
  logic              outEn, refLevel, boundary;

  refdiv_ctrl #(.DIV_W(DIV_W), .TRIM_W(TRIM_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrOp(wrOp),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .dpBoundary(boundary), .dpLevel(refLevel), .strobes(strobes),
    .shDivO(shDiv), .shTrimO(shTrim), .srcSelO(srcSel), .outEnO(outEn)
  );

  refdiv_core #(.N_SRC(N_SRC), .DIV_W(DIV_W), .TRIM_W(TRIM_W)) core_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .shDiv(shDiv), .shTrim(shTrim),
    .srcSel(srcSel), .srcTick(srcTick), .refLevel(refLevel), .boundary(boundary)
  );

  assign refClk = refLevel & outEn;
endmodule

// File: tb/frac_refclk_div_tb_top.sv
module frac_refclk_div_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  srcTick;
  logic        wrEn = 1'b0, wrAddr = 1'b0, rdAddr = 1'b0;
  logic [1:0]  wrOp = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        refClk;

  int checks = 0, errors = 0;
  int cyc = 0, prevCyc = 0;
  logic monArmed = 1'b0, prevValid = 1'b0, lastRef = 1'b0;
  int    expQ[$];
  string tagQ[$];
  logic [1:0] tickCnt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) tickCnt <= (tickCnt == 2'd2) ? 2'd0 : tickCnt + 2'd1;
  assign srcTick = {2'b00, tickCnt == 2'd0, 1'b1};

  frac_refclk_div dut_i (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrOp(wrOp), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .refClk(refClk)
  );

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: measures cycles between refClk edges, first reference is a rising edge
  always @(negedge clk) begin
    cyc++;
    if (!monArmed) begin
      prevValid = 1'b0;
      lastRef   = refClk;
    end else if (refClk !== lastRef) begin
      if (prevValid && expQ.size() > 0) begin
        int e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checkEq(t, cyc - prevCyc, e);
      end
      if (prevValid || refClk) begin
        prevValid = 1'b1;
        prevCyc   = cyc;
      end
      lastRef = refClk;
    end
  end

  task automatic busWrite(input logic a, input logic [1:0] op, input logic [31:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; wrAddr = a; wrOp = op; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic a, output logic [31:0] v);
    @(negedge clk);
    rdAddr = a;
    #1 v = rdData;
  endtask

  task automatic programRatio(input int div, input int trim, input int sel);
    busWrite(1'b0, 2'd0, (div << 8) | sel);
    busWrite(1'b1, 2'd0, trim);
    busWrite(1'b0, 2'd1, 32'h20);
    repeat (3) @(posedge clk);
  endtask

  task automatic enableRun();  busWrite(1'b0, 2'd1, 32'hC0); endtask

  task automatic stopRun();
    logic [31:0] v;
    busWrite(1'b0, 2'd2, 32'hC0);
    do busRead(1'b0, v); while (v[4]);
  endtask

  // driver: pushes expected half-period lengths (in system cycles)
  task automatic pushRatio(input string tag, input int div, input int trim,
                           input int per, input int n);
    int acc = 0;
    int base = (div == 0) ? 1 : div;
    for (int k = 1; k <= n; k++) begin
      int s = acc + trim;
      acc = s % 512;
      expQ.push_back((base + (s >= 512 ? 1 : 0)) * per);
      tagQ.push_back(tag);
    end
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    monArmed = 1'b0;
  endtask

  task automatic runRatio(input string tag, input int div, input int trim,
                          input int sel, input int per, input int n);
    programRatio(div, trim, sel);
    pushRatio(tag, div, trim, per, n);
    monArmed = 1'b1;
    enableRun();
    drain();
    stopRun();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    int hi;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    busRead(1'b0, v); checkEq("R1 ctrl", v, 0);
    busRead(1'b1, v); checkEq("R1 trim", v, 0);
    checkEq("R1 refClk", refClk, 0);

    // R2: store/set/clear and field widths
    busWrite(1'b0, 2'd0, 32'h905);
    busRead(1'b0, v); checkEq("R2 store", v, 32'h905);
    busWrite(1'b0, 2'd1, 32'h40);
    busRead(1'b0, v); checkEq("R2 set", v, 32'h945);
    busWrite(1'b0, 2'd2, 32'h40);
    busRead(1'b0, v); checkEq("R2 clear", v, 32'h905);
    busWrite(1'b0, 2'd3, 32'hFFFF_FFFF);
    busRead(1'b0, v); checkEq("R2 op none", v, 32'h905);
    busWrite(1'b1, 2'd0, 32'hFFFF_FFFF);
    busRead(1'b1, v); checkEq("R2 trim width", v, 32'h1FF);
    busWrite(1'b1, 2'd0, 0);

    // R8: idle switch clears on following cycle
    busWrite(1'b0, 2'd1, 32'h20);
    busRead(1'b0, v); checkEq("R8 pending", v[5], 1);
    busRead(1'b0, v); checkEq("R8 idle clear", v[5], 0);

    runRatio("R3", 3, 0, 0, 1, 6);
    runRatio("R4 half", 3, 256, 0, 1, 10);
    runRatio("R4 max trim", 1, 511, 0, 1, 10);
    runRatio("R6", 0, 100, 0, 1, 12);

    // R5: pass-through on source 1 (tick every 3 cycles)
    programRatio(0, 0, 1);
    for (int k = 0; k < 4; k++) begin
      expQ.push_back(1); tagQ.push_back("R5 high");
      expQ.push_back(2); tagQ.push_back("R5 low");
    end
    monArmed = 1'b1; enableRun(); drain(); stopRun();

    // R7: source 1 with ratio 2, the every-cycle source 0 is ignored
    runRatio("R7", 2, 0, 1, 3, 6);

    // R8 running switch: run at 2, shadow holds 4, switch applies 4
    programRatio(2, 0, 0);
    busWrite(1'b0, 2'd0, 32'h400);
    pushRatio("R8 before", 2, 0, 1, 3);
    monArmed = 1'b1; enableRun(); drain();
    busWrite(1'b0, 2'd1, 32'h20);
    do busRead(1'b0, v); while (v[5]);
    pushRatio("R8 after", 4, 0, 1, 4);
    monArmed = 1'b1; drain();

    // R9: field writes ignored while active
    busWrite(1'b0, 2'd0, 32'h7C2);
    busRead(1'b0, v); checkEq("R9 ctrl locked", v, 32'h4D0);
    busWrite(1'b1, 2'd0, 32'h55);
    busRead(1'b1, v); checkEq("R9 trim locked", v, 0);

    // R11: output enable gates only the output
    busWrite(1'b0, 2'd2, 32'h40);
    hi = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (refClk) hi++; end
    checkEq("R11 gated", hi, 0);
    busRead(1'b0, v); checkEq("R11 active", v[4], 1);
    stopRun();

    // R10: clearing ON mid high phase keeps the full high phase
    programRatio(6, 0, 0);
    enableRun();
    do @(negedge clk); while (refClk);
    do @(negedge clk); while (!refClk);
    hi = 1;
    fork
      begin
        @(negedge clk);
        while (refClk) begin hi++; @(negedge clk); end
      end
      busWrite(1'b0, 2'd2, 32'h80);
    join
    checkEq("R10 high length", hi, 6);
    busRead(1'b0, v); checkEq("R10 inactive", v[4], 0);
    hi = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (refClk) hi++; end
    checkEq("R10 quiet", hi, 0);

    finishRun();
  end
endmodule